// File: doc/BRIEF.md
# UART Character Buffer Controller

This block sits between a host-side register interface and the bit-level serializer and deserializer of a UART. It holds outgoing characters until the serializer takes them, and it holds incoming characters together with their error flags until the host reads them. A single control bit picks the depth of both paths. With the bit clear, each direction holds one character, like a plain holding register and receive buffer. With the bit set, each direction becomes a 64-entry first-in first-out queue.

The host writes an 8-bit control register. Besides the depth bit, this register carries two self-clearing bits that empty the transmit path or the receive path, and a two-bit field that sets the receive threshold interrupt level. The block drives the data-ready and transmit-request status outputs, the receive threshold interrupt, and four sticky error flags. A line-status read strobe clears the sticky flags. Characters shorter than 8 bits are stored right-justified. The receive error flags always sit in bits 10:8 of a stored word, whatever the character length.

Top module: `uart_fifo_buffer`

## Requirements
- R1: After reset, the control readback is 0x00 (single-entry mode), tx_req is 1, and data_ready, rx_irq, ser_tx_valid and all four sticky error flags are 0.
- R2: When control bit 0 is 0, each path holds one character. A host write to a full transmit holding register is dropped. A character arriving at a full receive holding register is handled as in R5.
- R3: When control bit 0 is 1, the transmit path keeps up to 64 characters and hands them out in write order. A host write to a full queue with no read in the same cycle is dropped.
- R4: Each receive word on host_rx_word has the character right-justified in bits 7:0, the parity-error flag in bit 8, the framing-error flag in bit 9 and the overrun flag in bit 10, whatever the character length. For example, a 5-bit character 10110 with no errors reads as 0x016.
- R5: A character that arrives at a full receive path, with no host read in the same cycle, is dropped. Bit 10 of the most recently stored word is then set, and err_overrun is set.
- R6: A control write with bit 2 set empties the transmit path, so that tx_req is 1 and ser_tx_valid is 0 after the edge. A control write with bit 2 clear leaves the transmit contents alone.
- R7: A control write with bit 1 set empties the receive path, so that data_ready is 0 after the edge. The overrun, parity, framing and break sticky flags keep their values.
- R8: Control bits 2 and 1 read back as written for the single cycle after the write, then return to 0 by themselves. Bits 5:3 always read 0.
- R9: In queue mode, rx_irq is 1 while the receive occupancy is at least the level set by control bits 7:6 (00 gives 1, 01 gives 8, 10 gives 16, 11 gives 32). In single-entry mode the level is 1.
- R10: data_ready is 1 exactly while the receive path holds at least one word. tx_req is 1 exactly while the transmit path is empty.
- R11: A host transmit write and a serializer read in the same cycle both take effect, and the occupancy is unchanged. A transmit-path reset in that cycle overrides both.
- R12: err_parity, err_framing and err_break are set by an arriving character that carries the flag, and err_overrun is set as in R5. A host_lsr_rd pulse clears all four flags, but a set in the same cycle wins.
- R13: A control write that changes bit 0 empties both paths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| ctl_readback | output | 8 | Current control register contents |
| host_tx_wr | input | 1 | Host pushes one transmit character |
| host_tx_data | input | 8 | Transmit character, right-justified |
| ser_tx_rd | input | 1 | Serializer takes the head character |
| ser_tx_data | output | 8 | Head transmit character |
| ser_tx_valid | output | 1 | A transmit character is available |
| ser_rx_wr | input | 1 | Deserializer delivers one character |
| ser_rx_char | input | 8 | Received character, right-justified |
| ser_rx_perr | input | 1 | Parity error on this character |
| ser_rx_ferr | input | 1 | Framing error on this character |
| ser_rx_brk | input | 1 | Break condition detected |
| host_rx_rd | input | 1 | Host removes the head receive word |
| host_rx_word | output | 11 | Head receive word: flags in 10:8, character in 7:0 |
| host_lsr_rd | input | 1 | Line status read, clears sticky flags |
| data_ready | output | 1 | Receive path not empty |
| tx_req | output | 1 | Transmit path empty |
| rx_irq | output | 1 | Receive occupancy at or above threshold |
| err_overrun | output | 1 | Sticky overrun flag |
| err_parity | output | 1 | Sticky parity error flag |
| err_framing | output | 1 | Sticky framing error flag |
| err_break | output | 1 | Sticky break flag |

## Verification
The bench first runs the single-entry mode with one character per direction. Here a second write is dropped and a second arrival marks an overrun on the stored word, which separates a capacity of one from a capacity of 64. The queue mode is then filled to exactly 64 and pushed one past. A simultaneous write and read at full occupancy shows that a full queue still accepts a write when a read happens in the same cycle. Arrivals carrying parity, framing and mixed flags show that the flag positions stay fixed, and threshold sweeps at levels 8 and 32 find the exact occupancy where the interrupt turns on. The reset bits are driven at 1 and at 0, and one reset lands in the same cycle as a write, which tells an emptied path from a path that was merely left alone.

// File: rtl/ufb_pkg.sv
package ufb_pkg;

    localparam int CHAR_W = 8;

    localparam int CTL_FIFO_EN = 0;
    localparam int CTL_RX_RST  = 1;
    localparam int CTL_TX_RST  = 2;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_8  = 2'b01,
        TRIG_16 = 2'b10,
        TRIG_32 = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] ch;
    } rx_word_t;

    localparam int RXW = $bits(rx_word_t);

    function automatic int unsigned trig_level(trig_sel_e s);
        case (s)
            TRIG_1:  return 1;
            TRIG_8:  return 8;
            TRIG_16: return 16;
            default: return 32;
        endcase
    endfunction

endpackage

// File: rtl/ufb_ctrl_reg.sv
module ufb_ctrl_reg
    import ufb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic [7:0] value,
    output logic       fifo_en,
    output trig_sel_e  trig,
    output logic       tx_flush,
    output logic       rx_flush
);

    typedef struct packed {
        logic [7:0] ctl;
    } st_t;

    st_t s_d, s_q;
    logic mode_change;

    always_comb begin
        s_d = s_q;
        // reset requests live for one cycle only
        s_d.ctl[CTL_TX_RST] = 1'b0;
        s_d.ctl[CTL_RX_RST] = 1'b0;
        if (wr) begin
            s_d.ctl = wdata;
        end
        s_d.ctl[5:3] = 3'b000;

        mode_change = wr && (wdata[CTL_FIFO_EN] != s_q.ctl[CTL_FIFO_EN]);
        tx_flush    = (wr && wdata[CTL_TX_RST]) || mode_change;
        rx_flush    = (wr && wdata[CTL_RX_RST]) || mode_change;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign value   = s_q.ctl;
    assign fifo_en = s_q.ctl[CTL_FIFO_EN];
    assign trig    = trig_sel_e'(s_q.ctl[7:6]);

endmodule

// File: rtl/ufb_tx_queue.sv
module ufb_tx_queue #(
    parameter int DEPTH = 64,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic             flush,
    input  logic             wr,
    input  logic [W-1:0]     wdata,
    input  logic             rd,
    output logic [W-1:0]     head,
    output logic             valid,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] cap;
    logic full, do_rd, do_wr;

    always_comb begin
        s_d   = s_q;
        cap   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full  = (s_q.cnt >= cap);
        do_rd = rd && (s_q.cnt != '0);
        do_wr = wr && (!full || do_rd);

        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_wr) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp          = s_q.wp + 1'b1;
            end
            if (do_rd) begin
                s_d.rp = s_q.rp + 1'b1;
            end
            s_d.cnt = s_q.cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign valid = (s_q.cnt != '0);
    assign count = s_q.cnt;

endmodule

// File: rtl/ufb_rx_queue.sv
module ufb_rx_queue
    import ufb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              flush,
    input  logic              wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              wperr,
    input  logic              wferr,
    input  logic              rd,
    output rx_word_t          head,
    output logic [CNT_W-1:0]  count,
    output logic              ovr_evt
);

    typedef struct packed {
        rx_word_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]     wp;
        logic [PTR_W-1:0]     rp;
        logic [CNT_W-1:0]     cnt;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] cap;
    logic [PTR_W-1:0] newest;
    logic full, do_rd, do_wr;
    rx_word_t incoming;

    always_comb begin
        s_d      = s_q;
        cap      = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
        full     = (s_q.cnt >= cap);
        do_rd    = rd && (s_q.cnt != '0);
        do_wr    = wr && (!full || do_rd);
        newest   = s_q.wp - 1'b1;
        incoming = '{ovr: 1'b0, ferr: wferr, perr: wperr, ch: wchar};
        ovr_evt  = 1'b0;

        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_wr) begin
                s_d.mem[s_q.wp] = incoming;
                s_d.wp          = s_q.wp + 1'b1;
            end else if (wr) begin
                // dropped arrival marks the last word kept
                ovr_evt               = 1'b1;
                s_d.mem[newest].ovr   = 1'b1;
            end
            if (do_rd) begin
                s_d.rp = s_q.rp + 1'b1;
            end
            s_d.cnt = s_q.cnt + CNT_W'(do_wr) - CNT_W'(do_rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign count = s_q.cnt;

endmodule

// File: rtl/ufb_status.sv
module ufb_status
    import ufb_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_ovr,
    input  logic             set_perr,
    input  logic             set_ferr,
    input  logic             set_brk,
    input  logic             clr,
    input  logic             fifo_en,
    input  trig_sel_e        trig,
    input  logic [CNT_W-1:0] rx_count,
    output logic             ovr,
    output logic             perr,
    output logic             ferr,
    output logic             brk,
    output logic             irq
);

    typedef struct packed {
        logic ovr;
        logic perr;
        logic ferr;
        logic brk;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W-1:0] level;

    always_comb begin
        s_d      = s_q;
        s_d.ovr  = (s_q.ovr  && !clr) || set_ovr;
        s_d.perr = (s_q.perr && !clr) || set_perr;
        s_d.ferr = (s_q.ferr && !clr) || set_ferr;
        s_d.brk  = (s_q.brk  && !clr) || set_brk;

        level = fifo_en ? CNT_W'(trig_level(trig)) : CNT_W'(1);
        irq   = (rx_count >= level);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ovr  = s_q.ovr;
    assign perr = s_q.perr;
    assign ferr = s_q.ferr;
    assign brk  = s_q.brk;

endmodule

// File: rtl/uart_fifo_buffer.sv
module uart_fifo_buffer
    import ufb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctrl_wr,
    input  logic [7:0]  ctrl_wdata,
    output logic [7:0]  ctl_readback,
    input  logic        host_tx_wr,
    input  logic [7:0]  host_tx_data,
    input  logic        ser_tx_rd,
    output logic [7:0]  ser_tx_data,
    output logic        ser_tx_valid,
    input  logic        ser_rx_wr,
    input  logic [7:0]  ser_rx_char,
    input  logic        ser_rx_perr,
    input  logic        ser_rx_ferr,
    input  logic        ser_rx_brk,
    input  logic        host_rx_rd,
    output logic [10:0] host_rx_word,
    input  logic        host_lsr_rd,
    output logic        data_ready,
    output logic        tx_req,
    output logic        rx_irq,
    output logic        err_overrun,
    output logic        err_parity,
    output logic        err_framing,
    output logic        err_break
);

    logic             fifo_en, tx_flush, rx_flush, ovr_evt;
    trig_sel_e        trig;
    logic [CNT_W-1:0] tx_count, rx_count;
    rx_word_t         rx_head;

    ufb_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (ctrl_wdata),
        .value    (ctl_readback),
        .fifo_en  (fifo_en),
        .trig     (trig),
        .tx_flush (tx_flush),
        .rx_flush (rx_flush)
    );

    ufb_tx_queue #(.DEPTH(DEPTH), .W(CHAR_W)) u_txq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .flush   (tx_flush),
        .wr      (host_tx_wr),
        .wdata   (host_tx_data),
        .rd      (ser_tx_rd),
        .head    (ser_tx_data),
        .valid   (ser_tx_valid),
        .count   (tx_count)
    );

    ufb_rx_queue #(.DEPTH(DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .flush   (rx_flush),
        .wr      (ser_rx_wr),
        .wchar   (ser_rx_char),
        .wperr   (ser_rx_perr),
        .wferr   (ser_rx_ferr),
        .rd      (host_rx_rd),
        .head    (rx_head),
        .count   (rx_count),
        .ovr_evt (ovr_evt)
    );

    ufb_status #(.CNT_W(CNT_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ovr  (ovr_evt),
        .set_perr (ser_rx_wr && ser_rx_perr),
        .set_ferr (ser_rx_wr && ser_rx_ferr),
        .set_brk  (ser_rx_wr && ser_rx_brk),
        .clr      (host_lsr_rd),
        .fifo_en  (fifo_en),
        .trig     (trig),
        .rx_count (rx_count),
        .ovr      (err_overrun),
        .perr     (err_parity),
        .ferr     (err_framing),
        .brk      (err_break),
        .irq      (rx_irq)
    );

    assign host_rx_word = rx_head;
    assign data_ready   = (rx_count != '0);
    assign tx_req       = (tx_count == '0);

endmodule

// File: rtl/ufb_checker.sv
module ufb_checker #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_wr,
    input logic [7:0]       ctrl_wdata,
    input logic [7:0]       ctl_readback,
    input logic             host_tx_wr,
    input logic             ser_tx_rd,
    input logic             ser_tx_valid,
    input logic             ser_rx_wr,
    input logic             host_rx_rd,
    input logic             host_lsr_rd,
    input logic             data_ready,
    input logic             tx_req,
    input logic             rx_irq,
    input logic             err_overrun,
    input logic             err_parity,
    input logic             err_framing,
    input logic             err_break,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count
);

    assert_tx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CNT_W'(DEPTH));

    assert_single_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_readback[0] |-> (tx_count <= CNT_W'(1) && rx_count <= CNT_W'(1)));

    assert_tx_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[2]) |=> (tx_req && !ser_tx_valid));

    assert_rx_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[1]) |=> !data_ready);

    assert_rx_reset_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_wdata[1] && !host_lsr_rd && !ser_rx_wr) |=>
        ($stable(err_overrun) && $stable(err_parity) && $stable(err_framing) && $stable(err_break)));

    assert_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> (ctl_readback[2:1] == 2'b00));

    assert_same_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && host_tx_wr && ser_tx_rd && ser_tx_valid) |=> $stable(tx_count));

    assert_irq_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> data_ready);

    assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_rx_wr && !host_rx_rd && !ctrl_wr && rx_count == CNT_W'(DEPTH)) |=>
        (err_overrun && rx_count == CNT_W'(DEPTH)));

endmodule

bind uart_fifo_buffer ufb_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_wr      (ctrl_wr),
    .ctrl_wdata   (ctrl_wdata),
    .ctl_readback (ctl_readback),
    .host_tx_wr   (host_tx_wr),
    .ser_tx_rd    (ser_tx_rd),
    .ser_tx_valid (ser_tx_valid),
    .ser_rx_wr    (ser_rx_wr),
    .host_rx_rd   (host_rx_rd),
    .host_lsr_rd  (host_lsr_rd),
    .data_ready   (data_ready),
    .tx_req       (tx_req),
    .rx_irq       (rx_irq),
    .err_overrun  (err_overrun),
    .err_parity   (err_parity),
    .err_framing  (err_framing),
    .err_break    (err_break),
    .tx_count     (tx_count),
    .rx_count     (rx_count)
);

// File: tb/uart_fifo_buffer_test.sv
module uart_fifo_buffer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctl_readback;
    logic        host_tx_wr = 1'b0;
    logic [7:0]  host_tx_data = '0;
    logic        ser_tx_rd = 1'b0;
    logic [7:0]  ser_tx_data;
    logic        ser_tx_valid;
    logic        ser_rx_wr = 1'b0;
    logic [7:0]  ser_rx_char = '0;
    logic        ser_rx_perr = 1'b0;
    logic        ser_rx_ferr = 1'b0;
    logic        ser_rx_brk = 1'b0;
    logic        host_rx_rd = 1'b0;
    logic [10:0] host_rx_word;
    logic        host_lsr_rd = 1'b0;
    logic        data_ready, tx_req, rx_irq;
    logic        err_overrun, err_parity, err_framing, err_break;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0]  tx_exp[$];
    logic [10:0] rx_exp[$];

    always #2 clk = ~clk;

    uart_fifo_buffer uut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic tx_put(input logic [7:0] d, input bit acc);
        host_tx_wr = 1'b1; host_tx_data = d;
        if (acc) tx_exp.push_back(d);
        tick();
        host_tx_wr = 1'b0;
    endtask

    task automatic tx_take();
        ser_tx_rd = 1'b1;
        tick();
        ser_tx_rd = 1'b0;
    endtask

    task automatic rx_put(input logic [7:0] c, input bit pe, input bit fe, input bit acc);
        ser_rx_wr = 1'b1; ser_rx_char = c; ser_rx_perr = pe; ser_rx_ferr = fe;
        if (acc) rx_exp.push_back({1'b0, fe, pe, c});
        else if (rx_exp.size() > 0) rx_exp[rx_exp.size()-1][10] = 1'b1;
        tick();
        ser_rx_wr = 1'b0; ser_rx_perr = 1'b0; ser_rx_ferr = 1'b0;
    endtask

    task automatic rx_take();
        host_rx_rd = 1'b1;
        tick();
        host_rx_rd = 1'b0;
    endtask

    // scoreboard monitor: compares at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ser_tx_rd && tx_exp.size() > 0) begin
                logic [7:0] e;
                e = tx_exp.pop_front();
                chk(ser_tx_valid && ser_tx_data == e, "R3 tx order", int'(ser_tx_data), int'(e));
            end
            if (host_rx_rd && rx_exp.size() > 0) begin
                logic [10:0] e;
                e = rx_exp.pop_front();
                chk(data_ready && host_rx_word == e, "R4 rx word", int'(host_rx_word), int'(e));
            end
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R1 reset state
        chk(ctl_readback == 8'h00, "R1 ctl", ctl_readback, 0);
        chk(tx_req == 1'b1 && !ser_tx_valid, "R1 tx_req", tx_req, 1);
        chk(!data_ready && !rx_irq, "R1 rx idle", {data_ready, rx_irq}, 0);
        chk({err_overrun, err_parity, err_framing, err_break} == 4'h0, "R1 flags",
            {err_overrun, err_parity, err_framing, err_break}, 0);

        // R2 single-entry transmit
        tx_put(8'hA5, 1'b1);
        tx_put(8'h3C, 1'b0);
        chk(!tx_req, "R10 tx_req low when holding", tx_req, 0);
        tx_take();
        chk(!ser_tx_valid && tx_req, "R2 second write dropped", ser_tx_valid, 0);

        // R2/R4/R5 single-entry receive, 5-bit char 10110
        rx_put(8'h16, 1'b0, 1'b0, 1'b1);
        chk(data_ready && rx_irq, "R9 single-mode level 1", {data_ready, rx_irq}, 3);
        rx_put(8'h07, 1'b0, 1'b0, 1'b0);
        chk(err_overrun, "R5 overrun flag", err_overrun, 1);
        chk(host_rx_word == 11'h416, "R4 R5 marked word", host_rx_word, 11'h416);
        rx_take();
        chk(!data_ready, "R10 data_ready cleared", data_ready, 0);

        // R12 clear
        host_lsr_rd = 1'b1; tick(); host_lsr_rd = 1'b0;
        chk(!err_overrun, "R12 clear", err_overrun, 0);

        // R13 switch to queue mode, level 8
        ctl(8'h01);
        chk(ctl_readback == 8'h01, "R13 mode on", ctl_readback, 1);
        ctl(8'h41);
        for (int i = 0; i < 7; i++) rx_put(8'(8'h20 + i), 1'(i == 2), 1'(i == 5), 1'b1);
        chk(!rx_irq, "R9 below level 8", rx_irq, 0);
        chk(err_parity && err_framing, "R12 flags set", {err_parity, err_framing}, 3);
        rx_put(8'h1F, 1'b1, 1'b1, 1'b1);
        chk(rx_irq, "R9 at level 8", rx_irq, 1);
        for (int i = 0; i < 8; i++) rx_take();
        chk(!data_ready && !rx_irq, "R10 rx drained", data_ready, 0);

        // R3 fill the transmit queue
        for (int i = 0; i < 64; i++) tx_put(8'(i * 3 + 1), 1'b1);
        tx_put(8'hEE, 1'b0);
        chk(!tx_req && ser_tx_valid, "R3 full", tx_req, 0);
        // R11 write and read together at full
        host_tx_wr = 1'b1; host_tx_data = 8'h5A; ser_tx_rd = 1'b1;
        tx_exp.push_back(8'h5A);
        tick();
        host_tx_wr = 1'b0; ser_tx_rd = 1'b0;
        for (int i = 0; i < 64; i++) tx_take();
        chk(tx_req && !ser_tx_valid && tx_exp.size() == 0, "R11 all 64 after swap",
            tx_exp.size(), 0);

        // R5 fill receive queue, one past
        for (int i = 0; i < 64; i++) rx_put(8'(i), 1'b0, 1'b0, 1'b1);
        rx_put(8'hFF, 1'b0, 1'b0, 1'b0);
        chk(err_overrun, "R5 queue overrun", err_overrun, 1);
        for (int i = 0; i < 64; i++) rx_take();
        chk(!data_ready, "R5 drained", data_ready, 0);

        // R6 bit 2 clear does nothing, bit 2 set empties
        tx_put(8'h11, 1'b1);
        tx_put(8'h22, 1'b1);
        ctl(8'h01);
        chk(ser_tx_valid && ser_tx_data == 8'h11, "R6 zero has no effect", ser_tx_data, 8'h11);
        ctl(8'h05);
        tx_exp.delete();
        chk(tx_req && !ser_tx_valid, "R6 tx reset", tx_req, 1);
        chk(ctl_readback == 8'h05, "R8 bit visible", ctl_readback, 5);
        tick();
        chk(ctl_readback == 8'h01, "R8 self-clear", ctl_readback, 1);

        // R7 receive reset keeps sticky flags
        host_lsr_rd = 1'b1; tick(); host_lsr_rd = 1'b0;
        ser_rx_brk = 1'b1;
        rx_put(8'h44, 1'b0, 1'b1, 1'b1);
        ser_rx_brk = 1'b0;
        ctl(8'h3B);
        rx_exp.delete();
        chk(!data_ready, "R7 rx emptied", data_ready, 0);
        chk(err_framing && err_break, "R7 flags kept", {err_framing, err_break}, 3);
        chk(ctl_readback == 8'h03, "R8 bits 5:3 zero", ctl_readback, 3);

        // R11 reset overrides simultaneous write
        tx_put(8'h77, 1'b1);
        ctrl_wr = 1'b1; ctrl_wdata = 8'h05; host_tx_wr = 1'b1; host_tx_data = 8'h88;
        tick();
        ctrl_wr = 1'b0; host_tx_wr = 1'b0;
        tx_exp.delete();
        chk(tx_req && !ser_tx_valid, "R11 reset priority", tx_req, 1);

        // R9 level 32
        ctl(8'hC1);
        for (int i = 0; i < 31; i++) rx_put(8'(i + 100), 1'b0, 1'b0, 1'b1);
        chk(!rx_irq, "R9 below level 32", rx_irq, 0);
        rx_put(8'h01, 1'b0, 1'b0, 1'b1);
        chk(rx_irq, "R9 at level 32", rx_irq, 1);

        // R13 mode change empties both paths
        tx_put(8'h99, 1'b1);
        ctl(8'h00);
        rx_exp.delete();
        tx_exp.delete();
        chk(!data_ready && tx_req, "R13 mode change flush", {data_ready, tx_req}, 1);

        // R12 set wins over clear
        host_lsr_rd = 1'b1;
        rx_put(8'h05, 1'b1, 1'b0, 1'b1);
        host_lsr_rd = 1'b0;
        chk(err_parity && !err_framing && !err_break, "R12 set wins",
            {err_parity, err_framing, err_break}, 4);
        rx_take();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule